// File: doc/BRIEF.md
# SPI Register-Access Packet Host

This block is an SPI bus host that reads and writes 16-bit registers in up to twelve client devices sharing one bus. A single request carries a device number, a direction, an 8-bit register number, and either one 16-bit word to write or the number of 16-bit words to read back. The block checks the request and builds the packet. It runs one continuous chip-select window with a divided serial clock, shifts the packet out, and hands each word it reads back to the caller on a valid/data stream. A one-cycle done pulse marks the end of the packet.

Every packet opens with a control byte. Bit 7 of this byte is the direction and bits 3:0 are the device number. The register byte comes next. A write then sends one data word. A read sends a byte holding the word count and then clocks in that many words from the client. Requests the bus cannot serve are refused with an error pulse and cause no bus activity. The serial clock rate is derived at elaboration time from the system clock frequency.

Top module: `spi_pkt_host`

## Requirements
- R1: After reset, cs_no is high, sck_o is low, req_ready_o is high, and rd_valid_o, done_o and err_o are low.
- R2: The first byte of every packet is {direction, 3'b000, device[3:0]}, where direction is 1 for a write and 0 for a read. The second byte is the register number. All bytes and words go out most significant bit first.
- R3: A write packet is exactly 32 bits long: the control byte, the register byte and the 16-bit write word. The count input has no effect on a write, and a count of 0 is accepted for a write.
- R4: A read packet sends the control byte, the register byte and the count byte, which gives 24 host bits. It then clocks in count×16 bits from miso_i. Each group of 16 bits is presented as one rd_valid_o pulse with its first received bit in rd_data_o[15]. Counts from 1 to 255 are served.
- R5: The bus uses SPI mode 0. sck_o idles low, miso_i is sampled on the rising edge, and mosi_o changes only while sck_o is low.
- R6: One sck_o period is 2×HALF system clocks, where HALF = CLK_HZ/(2×SCK_HZ) with a minimum of 1.
- R7: cs_no falls exactly once per packet and stays low from before the first rising edge of sck_o until after the last falling edge. It is low for at least HALF clocks before that first rising edge and for at least HALF clocks after that last falling edge.
- R8: When a packet ends, done_o pulses for one clock in the same cycle that cs_no returns high, and req_ready_o is high again.
- R9: A request with a device number above 11 gives a one-cycle err_o pulse and no chip-select or clock activity.
- R10: A read request with a count of 0 gives a one-cycle err_o pulse and no chip-select or clock activity.
- R11: While a packet is in progress, req_ready_o is low and a request presented on the inputs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Host idle, request taken this cycle |
| req_dev_i | input | 4 | Target device number, 0 to 11 |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_reg_i | input | 8 | Register number |
| req_wdata_i | input | 16 | Word to write |
| req_count_i | input | 8 | Number of words to read |
| rd_valid_o | output | 1 | Read word valid, one cycle |
| rd_data_o | output | 16 | Read word |
| done_o | output | 1 | Packet finished, one cycle |
| err_o | output | 1 | Request refused, one cycle |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Host-to-client data |
| miso_i | input | 1 | Client-to-host data |

## Verification
The bench builds the host with CLK_HZ at 200 MHz and SCK_HZ at 25 MHz, which gives HALF = 4. At that setting a read of the full 255-word count, which is 4104 bit times, runs to completion in about 33,000 clocks. The bench can therefore exercise the widest bit counter and the word-boundary logic for every word of the longest packet, besides the short write and read packets. The default 1 MHz setting changes only the tick divider depth, and every check is written in units of HALF.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;
  localparam int unsigned DEV_W       = 4;
  localparam int unsigned MAX_DEV     = 11;
  localparam int unsigned REG_W       = 8;
  localparam int unsigned WORD_W      = 16;
  localparam int unsigned CNT_W       = 8;
  localparam int unsigned HDR_W       = 8 + REG_W + WORD_W;
  localparam int unsigned WR_BITS     = HDR_W;
  localparam int unsigned RD_HDR_BITS = 8 + REG_W + CNT_W;
  localparam int unsigned MAX_BITS    = RD_HDR_BITS + WORD_W * ((1 << CNT_W) - 1);
  localparam int unsigned BITS_W      = $clog2(MAX_BITS + 1);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL
  } pkt_state_e;
endpackage

// File: rtl/spi_sck_tick.sv
module spi_sck_tick #(
  parameter int unsigned HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(HALF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (HALF > 1) begin : g_gap
      p_tick_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/spi_pkt_frame.sv
module spi_pkt_frame
  import spi_pkt_pkg::*;
(
  input  logic [DEV_W-1:0]  dev_i,
  input  logic              write_i,
  input  logic [REG_W-1:0]  reg_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  output logic              ok_o,
  output logic [HDR_W-1:0]  hdr_o,
  output logic [BITS_W-1:0] nbits_o
);
  logic [7:0] ctrl;

  always_comb begin
    ctrl    = {write_i, 3'b000, dev_i};
    ok_o    = (dev_i <= DEV_W'(MAX_DEV)) && (write_i || (count_i != '0));
    if (write_i) begin
      hdr_o   = {ctrl, reg_i, wdata_i};
      nbits_o = BITS_W'(WR_BITS);
    end else begin
      hdr_o   = {ctrl, reg_i, count_i, {(HDR_W - RD_HDR_BITS){1'b0}}};
      nbits_o = BITS_W'(RD_HDR_BITS) + (BITS_W'(count_i) << $clog2(WORD_W));
    end
  end
endmodule

// File: rtl/spi_pkt_rx.sv
module spi_pkt_rx
  import spi_pkt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_i,
  input  logic              word_end_i,
  input  logic              miso_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  logic [WORD_W-2:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      if (sample_i) begin
        sr_q <= {sr_q[WORD_W-3:0], miso_i};
        if (word_end_i) begin
          valid_o <= 1'b1;
          data_o  <= {sr_q, miso_i};
        end
      end
    end
  end
endmodule

// File: rtl/spi_pkt_host.sv
module spi_pkt_host
  import spi_pkt_pkg::*;
#(
  parameter int unsigned CLK_HZ = 200_000_000,
  parameter int unsigned SCK_HZ = 1_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [DEV_W-1:0]  req_dev_i,
  input  logic              req_write_i,
  input  logic [REG_W-1:0]  req_reg_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  input  logic [CNT_W-1:0]  req_count_i,
  output logic              rd_valid_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              done_o,
  output logic              err_o,
  output logic              sck_o,
  output logic              cs_no,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int unsigned HALF_RAW = CLK_HZ / (2 * SCK_HZ);
  localparam int unsigned HALF     = (HALF_RAW < 1) ? 1 : HALF_RAW;

  pkt_state_e        state_q;
  logic [HDR_W-1:0]  tx_q;
  logic [BITS_W-1:0] nbits_q, bit_q;
  logic              rd_q, sck_q, cs_q, done_q, err_q;

  logic              frm_ok;
  logic [HDR_W-1:0]  frm_hdr;
  logic [BITS_W-1:0] frm_bits;
  logic              tick, rise, sample, word_end;
  logic [3:0]        word_pos;

  spi_pkt_frame u_frame (
    .dev_i   (req_dev_i),
    .write_i (req_write_i),
    .reg_i   (req_reg_i),
    .wdata_i (req_wdata_i),
    .count_i (req_count_i),
    .ok_o    (frm_ok),
    .hdr_o   (frm_hdr),
    .nbits_o (frm_bits)
  );

  spi_sck_tick #(.HALF(HALF)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q != ST_IDLE),
    .tick_o (tick)
  );

  // rising edge of sck: first one leaves LEAD, later ones come from SHIFT with sck low
  assign rise     = tick && ((state_q == ST_LEAD) || (state_q == ST_SHIFT && !sck_q));
  assign word_pos = bit_q[3:0] - 4'(RD_HDR_BITS % WORD_W);
  assign word_end = (word_pos == 4'(WORD_W - 1));
  assign sample   = rise && rd_q && (bit_q >= BITS_W'(RD_HDR_BITS));

  spi_pkt_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample),
    .word_end_i (word_end),
    .miso_i     (miso_i),
    .valid_o    (rd_valid_o),
    .data_o     (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tx_q    <= '0;
      nbits_q <= '0;
      bit_q   <= '0;
      rd_q    <= 1'b0;
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            if (!frm_ok) begin
              err_q <= 1'b1;
            end else begin
              tx_q    <= frm_hdr;
              nbits_q <= frm_bits;
              rd_q    <= !req_write_i;
              bit_q   <= '0;
              cs_q    <= 1'b0;
              state_q <= ST_LEAD;
            end
          end
        end
        ST_LEAD: begin
          if (tick) begin
            sck_q   <= 1'b1;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sck_q) begin
              sck_q <= 1'b1;
            end else begin
              sck_q <= 1'b0;
              tx_q  <= {tx_q[HDR_W-2:0], 1'b0};
              bit_q <= bit_q + 1'b1;
              if (bit_q == nbits_q - 1'b1) state_q <= ST_TRAIL;
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            cs_q    <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign sck_o       = sck_q;
  assign cs_no       = cs_q;
  assign mosi_o      = tx_q[HDR_W-1];
  assign done_o      = done_q;
  assign err_o       = err_q;

  p_sck_idle_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);
  p_mosi_hold_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));
  p_rd_in_pkt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !cs_no);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && req_ready_o) ##1 !done_o);
  p_err_no_bus_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (cs_no && !sck_o));
  p_busy_blocks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !req_ready_o);
  p_cs_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !done_o && $past(!cs_no) && !$past(done_o) && sck_o) |=> !cs_no);
endmodule

// File: tb/tb_spi_pkt_host.sv
`timescale 1ns/1ps
module tb_spi_pkt_host;
  localparam int unsigned CLK_HZ = 200_000_000;
  localparam int unsigned SCK_HZ = 25_000_000;
  localparam int HALF = CLK_HZ / (2 * SCK_HZ);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_dev = '0;
  logic req_write = 1'b0;
  logic [7:0] req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0] req_count = '0;
  logic miso = 1'b0;
  logic req_ready, rd_valid, done, err, sck, cs_n, mosi;
  logic [15:0] rd_data;

  always #2.5 clk = ~clk;

  spi_pkt_host #(.CLK_HZ(CLK_HZ), .SCK_HZ(SCK_HZ)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_dev_i(req_dev), .req_write_i(req_write), .req_reg_i(req_reg),
    .req_wdata_i(req_wdata), .req_count_i(req_count),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .done_o(done), .err_o(err),
    .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  int n_checks = 0, n_fail = 0;
  int cyc = 0, n_bits = 0, pkt_base = 0, n_rd = 0, n_done = 0, n_err = 0, cs_falls = 0;
  int per_bad = 0, mosi_bad = 0, sck_out = 0;
  int cs_fall_cyc = 0, cs_rise_cyc = 0, first_rise_cyc = 0, last_rise_cyc = 0, last_fall_cyc = 0;
  logic cap [0:8191];
  logic [15:0] rd_words [0:511];
  logic [15:0] exp_rd [0:255];
  logic prev_sck = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;

  // client model and observers, all sampled away from the active edge
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rd_valid) begin
      rd_words[n_rd % 512] = rd_data;
      n_rd = n_rd + 1;
    end
    if (done) n_done = n_done + 1;
    if (err) n_err = n_err + 1;
    if (prev_cs && !cs_n) begin
      cs_falls = cs_falls + 1;
      cs_fall_cyc = cyc;
      pkt_base = n_bits;
    end
    if (!prev_cs && cs_n) cs_rise_cyc = cyc;
    if (!prev_sck && sck) begin
      cap[n_bits % 8192] = mosi;
      if (n_bits == pkt_base) first_rise_cyc = cyc;
      else if (cyc - last_rise_cyc != 2 * HALF) per_bad = per_bad + 1;
      if (cs_n) sck_out = sck_out + 1;
      last_rise_cyc = cyc;
      n_bits = n_bits + 1;
    end
    if (prev_sck && !sck) begin
      last_fall_cyc = cyc;
      if (n_bits - pkt_base >= 24) begin
        int idx;
        idx = n_bits - pkt_base - 24;
        if (idx / 16 < 256) miso <= exp_rd[idx / 16][15 - (idx % 16)];
      end
    end
    if (mosi != prev_mosi && sck) mosi_bad = mosi_bad + 1;
    prev_sck = sck;
    prev_cs = cs_n;
    prev_mosi = mosi;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int field(input int start, input int len);
    int v = 0;
    for (int i = 0; i < len; i++) v = (v << 1) | int'(cap[(pkt_base + start + i) % 8192]);
    return v;
  endfunction

  task automatic send(input bit wr, input logic [3:0] dv, input logic [7:0] rg,
                      input logic [15:0] wd, input logic [7:0] ct);
    int d0 = n_done, e0 = n_err;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_dev = dv; req_reg = rg; req_wdata = wd; req_count = ct;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      if (n_done != d0 || n_err != e0) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(cs_n == 1'b1 && sck == 1'b0, "R1 bus idle", {cs_n, sck}, 2'b10);
    check(req_ready == 1'b1, "R1 ready", req_ready, 1);
    check(!rd_valid && !done && !err, "R1 flags", {rd_valid, done, err}, 0);
  endtask

  task automatic t_write();
    int b0 = n_bits, f0 = cs_falls, d0 = n_done, pb = per_bad, mb = mosi_bad;
    send(1'b1, 4'd5, 8'hA7, 16'hC35A, 8'd0);
    check(n_bits - b0 == 32, "R3 write length", n_bits - b0, 32);
    check(field(0, 8) == 8'h85, "R2 write ctrl byte", field(0, 8), 8'h85);
    check(field(8, 8) == 8'hA7, "R2 reg byte", field(8, 8), 8'hA7);
    check(field(16, 16) == 16'hC35A, "R3 write word (count 0 ignored)", field(16, 16), 16'hC35A);
    check(mosi_bad == mb, "R5 mosi changes only with sck low", mosi_bad - mb, 0);
    check(per_bad == pb, "R6 sck period", per_bad - pb, 0);
    check(cs_falls - f0 == 1, "R7 single cs window", cs_falls - f0, 1);
    check(first_rise_cyc - cs_fall_cyc >= HALF, "R7 cs lead", first_rise_cyc - cs_fall_cyc, HALF);
    check(cs_rise_cyc - last_fall_cyc >= HALF, "R7 cs trail", cs_rise_cyc - last_fall_cyc, HALF);
    check(n_done - d0 == 1 && req_ready, "R8 done pulse and ready", n_done - d0, 1);
  endtask

  task automatic t_read(input logic [3:0] dv, input logic [7:0] rg, input int cnt);
    int b0 = n_bits, r0 = n_rd, bad = 0;
    for (int i = 0; i < 256; i++) exp_rd[i] = 16'(i * 16'h1357) ^ 16'hA5C3 ^ 16'(cnt);
    send(1'b0, dv, rg, 16'hFFFF, 8'(cnt));
    check(field(0, 8) == {4'h0, dv}, "R2 read ctrl byte", field(0, 8), {4'h0, dv});
    check(field(8, 8) == rg, "R2 read reg byte", field(8, 8), rg);
    check(field(16, 8) == cnt, "R4 count byte", field(16, 8), cnt);
    check(n_bits - b0 == 24 + 16 * cnt, "R4 read length", n_bits - b0, 24 + 16 * cnt);
    check(n_rd - r0 == cnt, "R4 word count", n_rd - r0, cnt);
    for (int i = 0; i < cnt; i++)
      if (rd_words[(r0 + i) % 512] != exp_rd[i]) begin
        if (bad == 0) check(1'b0, "R4 read data (R5 sampling)", rd_words[(r0 + i) % 512], exp_rd[i]);
        bad++;
      end
    if (bad == 0) check(1'b1, "R4 read data", 0, 0);
    check(sck_out == 0, "R7 sck only inside cs", sck_out, 0);
  endtask

  task automatic t_reject(input bit wr, input logic [3:0] dv, input logic [7:0] ct, input string req);
    int e0 = n_err, f0 = cs_falls, b0 = n_bits;
    send(wr, dv, 8'h10, 16'h1234, ct);
    check(n_err - e0 == 1, {req, " error pulse"}, n_err - e0, 1);
    check(cs_falls == f0 && n_bits == b0, {req, " no bus activity"}, cs_falls - f0, 0);
  endtask

  task automatic t_busy();
    int f0 = cs_falls, b0 = n_bits, d0 = n_done;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_dev = 4'd3; req_reg = 8'h5E; req_wdata = 16'h0F0F;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    check(req_ready == 1'b0, "R11 ready low while busy", req_ready, 0);
    req_valid = 1'b1; req_write = 1'b0; req_dev = 4'd2; req_count = 8'd4;
    repeat (10) @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      if (n_done != d0) break;
      @(negedge clk);
    end
    repeat (60) @(negedge clk);
    check(cs_falls - f0 == 1 && n_bits - b0 == 32, "R11 overlapping request ignored",
          n_bits - b0, 32);
    check(field(0, 8) == 8'h83, "R11 first request kept", field(0, 8), 8'h83);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_write();
    t_read(4'd11, 8'h3C, 3);
    t_read(4'd7, 8'h01, 1);
    t_read(4'd0, 8'hF0, 255);
    t_reject(1'b1, 4'd12, 8'd0, "R9 device 12");
    t_reject(1'b0, 4'd15, 8'd2, "R9 device 15");
    t_reject(1'b0, 4'd4, 8'd0, "R10 read count 0");
    t_busy();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule